// File: doc/BRIEF.md
# Dual-Mode Serial Frame Receiver

This block takes 16-bit command words from a synchronous serial host and hands each complete word to a decoder through a one-cycle commit strobe. The serial clock, the active-low frame sync and the data line are all oversampled by a fast system clock. Edges are detected in that clock domain. A data bit is taken on every falling edge of the serial clock while a frame is open, most significant bit first.

Two framing styles are selectable. In controller style the frame sync must stay low for all 16 bits. A sync that rises early throws the word away. A complete word is committed only when the sync rises. In DSP style the sync is only a start pulse: the frame runs on and commits on its 16th bit, whatever the sync does. A new start is honoured only after a serial clock falling edge has been seen with the receiver idle.

A delayed copy of the data line is available for daisy-chaining. When enabled, it repeats each sampled bit 16 serial clocks later.

Top module: `serial_frame_rx`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `word_o` is 0, `commit_o` is 0 and `dout_o` is 0.
- R2: Bits are taken on falling edges of `sclk_i` while a frame is open. The first bit taken lands in `word_o[15]` and the 16th in `word_o[0]`.
- R3: `commit_o` is high for exactly one `clk_i` cycle per accepted word. `word_o` changes only in that cycle and otherwise holds its value.
- R4: With `dsp_mode_i`=0 (controller style), a word with all 16 bits taken is committed only after the following rising edge of `fs_ni`, and never before it.
- R5: With `dsp_mode_i`=0, a rise of `fs_ni` before the 16th falling edge discards the frame: there is no commit and `word_o` is unchanged.
- R6: With `dsp_mode_i`=0, falling edges of `sclk_i` after the 16th and before `fs_ni` rises do not alter the committed word.
- R7: With `dsp_mode_i`=1 (DSP style), the word commits after the 16th falling edge, even when `fs_ni` went high after the first few bits.
- R8: With `dsp_mode_i`=1, a falling edge of `fs_ni` starts a frame only if a falling edge of `sclk_i` was seen while the receiver was idle since the last frame. Otherwise the start is ignored and no word is committed.
- R9: With `dsp_mode_i`=1, a falling edge of `fs_ni` while a frame is being counted is ignored, and the frame completes with all 16 bits.
- R10: Every falling edge of `sclk_i` shifts `din_i` into a 16-bit delay line, whether or not a frame is open or the output is enabled. `dout_o` shows the bit taken 16 falling edges earlier when `dout_en_i`=1, and is 0 when `dout_en_i`=0.
- R11: Each of `sclk_i`, `fs_ni` and `din_i` passes through a two-stage synchronizer. An input edge applied between rising edges n-1 and n of `clk_i` affects registered outputs at rising edge n+2. `sclk_i` must run at no more than a quarter of the `clk_i` rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial data from the host |
| fs_ni | input | 1 | Active-low frame sync |
| dsp_mode_i | input | 1 | 1 = DSP framing style, 0 = controller framing style |
| dout_en_i | input | 1 | Enables the daisy-chain output |
| word_o | output | 16 | Last committed word, first bit received in bit 15 |
| commit_o | output | 1 | One-cycle strobe marking a new word on `word_o` |
| dout_o | output | 1 | Daisy-chain output, the data line delayed by 16 serial clocks |

## Verification
The bench builds the block with its defaults: 16-bit words, two synchronizer stages and a 16-deep delay line. It runs the serial clock at one eighth of the system clock. With 16 bits, the early-rise cancel, the extra trailing edges in controller style and a restart mid-frame in DSP style can all be provoked in a few hundred cycles. With two stages the three-cycle commit latency can be pinned to an exact clock edge. The 16-deep line lets a disabled-output frame be revealed bit by bit once the output is switched on.

// File: rtl/frx_pkg.sv
package frx_pkg;
  typedef enum logic [1:0] {
    FRX_IDLE  = 2'd0,
    FRX_SHIFT = 2'd1,
    FRX_HOLD  = 2'd2
  } frx_state_e;
endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] fall_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '0;
      else         chain <= {chain[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= q_o;
  end

  assign fall_o = prev_q & ~q_o;
  assign rise_o = ~prev_q & q_o;
endmodule

// File: rtl/frx_frame.sv
module frx_frame
  import frx_pkg::*;
#(
  parameter int WORD_BITS = 16,
  localparam int CNT_W    = $clog2(WORD_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_fall_i,
  input  logic                 fs_fall_i,
  input  logic                 fs_rise_i,
  input  logic                 din_i,
  input  logic                 dsp_mode_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 commit_o,
  output logic [CNT_W-1:0]     bit_cnt_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

  frx_state_e           state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [WORD_BITS-1:0] shreg_q;
  logic                 armed_q;
  logic [WORD_BITS-1:0] shreg_nxt;
  logic                 start_ok;

  assign shreg_nxt = {shreg_q[WORD_BITS-2:0], din_i};
  // DSP style needs a clock edge seen while idle before it accepts a start
  assign start_ok  = fs_fall_i && (!dsp_mode_i || armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= FRX_IDLE;
      cnt_q    <= '0;
      shreg_q  <= '0;
      armed_q  <= 1'b0;
      word_o   <= '0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      unique case (state_q)
        FRX_IDLE: begin
          if (start_ok) begin
            state_q <= FRX_SHIFT;
            cnt_q   <= '0;
            armed_q <= 1'b0;
          end else if (sclk_fall_i) begin
            armed_q <= 1'b1;
          end
        end
        FRX_SHIFT: begin
          if (!dsp_mode_i && fs_rise_i) begin
            state_q <= FRX_IDLE;
            cnt_q   <= '0;
          end else if (sclk_fall_i) begin
            shreg_q <= shreg_nxt;
            if (cnt_q == LAST_BIT) begin
              cnt_q <= '0;
              if (dsp_mode_i) begin
                word_o   <= shreg_nxt;
                commit_o <= 1'b1;
                state_q  <= FRX_IDLE;
              end else begin
                state_q <= FRX_HOLD;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        FRX_HOLD: begin
          if (fs_rise_i) begin
            word_o   <= shreg_q;
            commit_o <= 1'b1;
            state_q  <= FRX_IDLE;
          end
        end
        default: state_q <= FRX_IDLE;
      endcase
    end
  end

  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/frx_delay.sv
module frx_delay #(
  parameter int DEPTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic bit_i,
  output logic tap_o
);
  logic [DEPTH-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      line_q <= '0;
    else if (shift_i) line_q <= {line_q[DEPTH-2:0], bit_i};
  end

  assign tap_o = line_q[DEPTH-1];
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int WORD_BITS   = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(WORD_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 din_i,
  input  logic                 fs_ni,
  input  logic                 dsp_mode_i,
  input  logic                 dout_en_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 commit_o,
  output logic                 dout_o
);
  localparam int IDX_SCLK = 0;
  localparam int IDX_FS   = 1;
  localparam int IDX_DIN  = 2;

  logic [2:0]       lvl, fall, rise;
  logic             sclk_fall, fs_fall, fs_rise, s_din;
  logic             tap;
  logic [CNT_W-1:0] bit_cnt;
  logic             sync_unused;

  frx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({din_i, fs_ni, sclk_i}),
    .q_o    (lvl),
    .fall_o (fall),
    .rise_o (rise)
  );

  assign sclk_fall   = fall[IDX_SCLK];
  assign fs_fall     = fall[IDX_FS];
  assign fs_rise     = rise[IDX_FS];
  assign s_din       = lvl[IDX_DIN];
  assign sync_unused = ^{rise[IDX_SCLK], rise[IDX_DIN], fall[IDX_DIN], lvl[IDX_SCLK], lvl[IDX_FS]};

  frx_frame #(.WORD_BITS(WORD_BITS)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_fall_i (sclk_fall),
    .fs_fall_i   (fs_fall),
    .fs_rise_i   (fs_rise),
    .din_i       (s_din),
    .dsp_mode_i  (dsp_mode_i),
    .word_o      (word_o),
    .commit_o    (commit_o),
    .bit_cnt_o   (bit_cnt)
  );

  frx_delay #(.DEPTH(WORD_BITS)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (sclk_fall),
    .bit_i   (s_din),
    .tap_o   (tap)
  );

  assign dout_o = dout_en_i & tap;
endmodule

// File: rtl/frx_checker.sv
module frx_checker #(
  parameter int WORD_BITS = 16,
  parameter int CNT_W     = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 dsp_mode_i,
  input logic                 dout_en_i,
  input logic [WORD_BITS-1:0] word_o,
  input logic                 commit_o,
  input logic                 dout_o,
  input logic                 sclk_fall,
  input logic                 fs_rise,
  input logic [CNT_W-1:0]     bit_cnt
);
  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  assert_word_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |-> $stable(word_o));

  assert_ctrl_commit_on_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && !dsp_mode_i) |-> $past(fs_rise));

  assert_early_rise_drops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_rise && !dsp_mode_i && bit_cnt != '0) |=> !commit_o);

  assert_dsp_commit_on_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && dsp_mode_i) |-> $past(sclk_fall));

  assert_dout_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_en_i |-> !dout_o);
endmodule

bind serial_frame_rx frx_checker #(.WORD_BITS(WORD_BITS), .CNT_W(CNT_W)) u_frx_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dsp_mode_i (dsp_mode_i),
  .dout_en_i  (dout_en_i),
  .word_o     (word_o),
  .commit_o   (commit_o),
  .dout_o     (dout_o),
  .sclk_fall  (sclk_fall),
  .fs_rise    (fs_rise),
  .bit_cnt    (bit_cnt)
);

// File: tb/tb_serial_frame_rx.sv
module tb_serial_frame_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, din = 1'b0, fs_n = 1'b1, dsp = 1'b0, den = 1'b0;
  logic [15:0] word;
  logic commit, dout;

  int n_chk = 0, n_fail = 0, n_commit = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_frame_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .din_i(din), .fs_ni(fs_n),
    .dsp_mode_i(dsp), .dout_en_i(den), .word_o(word), .commit_o(commit), .dout_o(dout)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic put_bit(input logic b);
    din = b; step(4); sclk = 1'b0; step(4); sclk = 1'b1;
  endtask

  task automatic put_bits(input logic [15:0] w, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) put_bit(w[i]);
  endtask

  // Behavioural reference: input history queues, frame state, delay queue
  bit qs[$], qf[$], qd[$], dq[$];
  int m_st, m_cnt;
  logic [15:0] m_sh, m_word;
  bit m_commit, m_armed;

  always @(negedge clk) begin
    if (!rst_n) begin
      qs = '{0, 0, 0, 0}; qf = '{0, 0, 0, 0}; qd = '{0, 0, 0, 0};
      dq.delete();
      for (int i = 0; i < 16; i++) dq.push_back(0);
      m_st = 0; m_cnt = 0; m_sh = '0; m_word = '0; m_commit = 0; m_armed = 0;
    end else begin
      bit sf, ff, fr, d;
      chk(commit == m_commit, "R3/R11 commit vs model", 32'(commit), 32'(m_commit));
      chk(word == m_word, "R2 word vs model", 32'(word), 32'(m_word));
      chk(dout == (den & dq[15]), "R10 dout vs model", 32'(dout), 32'(den & dq[15]));
      if (commit) n_commit++;
      qs.push_front(sclk); void'(qs.pop_back());
      qf.push_front(fs_n); void'(qf.pop_back());
      qd.push_front(din);  void'(qd.pop_back());
      sf = qs[3] & ~qs[2];
      ff = qf[3] & ~qf[2];
      fr = ~qf[3] & qf[2];
      d  = qd[2];
      m_commit = 0;
      if (m_st == 0) begin
        if (ff && (!dsp || m_armed)) begin m_st = 1; m_cnt = 0; m_armed = 0; end
        else if (sf) m_armed = 1;
      end else if (m_st == 1) begin
        if (!dsp && fr) begin m_st = 0; m_cnt = 0; end
        else if (sf) begin
          m_sh = {m_sh[14:0], d};
          m_cnt++;
          if (m_cnt == 16) begin
            m_cnt = 0;
            if (dsp) begin m_word = m_sh; m_commit = 1; m_st = 0; end
            else m_st = 2;
          end
        end
      end else begin
        if (fr) begin m_word = m_sh; m_commit = 1; m_st = 0; end
      end
      if (sf) begin dq.push_front(d); void'(dq.pop_back()); end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    step(4);
    chk(word == 16'h0, "R1 reset word", 32'(word), 0);
    chk(commit == 1'b0, "R1 reset commit", 32'(commit), 0);
    chk(dout == 1'b0, "R1 reset dout", 32'(dout), 0);
    rst_n = 1'b1;
    step(4);

    // R4 / R2: controller-style frame commits only on FS rise
    c = n_commit;
    fs_n = 1'b0; step(4);
    put_bits(16'hA5C3, 15, 0);
    step(4);
    chk(n_commit == c, "R4 no commit before FS rise", 32'(n_commit), 32'(c));
    fs_n = 1'b1; step(6);
    chk(n_commit == c + 1, "R4 commit after FS rise", 32'(n_commit), 32'(c + 1));
    chk(word == 16'hA5C3, "R2 MSB-first word", 32'(word), 32'h A5C3);

    // R5: early FS rise discards
    c = n_commit;
    fs_n = 1'b0; step(4);
    put_bits(16'h1234, 15, 6);
    fs_n = 1'b1; step(8);
    chk(n_commit == c, "R5 aborted frame no commit", 32'(n_commit), 32'(c));
    chk(word == 16'hA5C3, "R5 word unchanged", 32'(word), 32'hA5C3);

    // R6: trailing edges before FS rise ignored
    c = n_commit;
    fs_n = 1'b0; step(4);
    put_bits(16'h5AF0, 15, 0);
    put_bit(1'b1); put_bit(1'b1);
    fs_n = 1'b1; step(6);
    chk(word == 16'h5AF0, "R6 trailing edges ignored", 32'(word), 32'h5AF0);
    chk(n_commit == c + 1, "R3 one pulse per word", 32'(n_commit), 32'(c + 1));

    // R7 / R11: DSP style, FS rises after two bits, commit on 16th edge
    dsp = 1'b1; step(2);
    put_bit(1'b0);
    fs_n = 1'b0; step(4);
    put_bits(16'h3C96, 15, 14);
    fs_n = 1'b1;
    put_bits(16'h3C96, 13, 1);
    din = 1'b0; step(4); sclk = 1'b0;
    step(2);
    chk(commit == 1'b0, "R11 no commit two cycles after edge", 32'(commit), 0);
    step(1);
    chk(commit == 1'b1, "R7/R11 commit three cycles after edge", 32'(commit), 1);
    chk(word == 16'h3C96, "R7 DSP word", 32'(word), 32'h3C96);
    step(1);
    chk(commit == 1'b0, "R3 pulse ends", 32'(commit), 0);
    step(1); sclk = 1'b1; step(4);

    // R8: start without a preceding idle SCLK edge is ignored
    c = n_commit;
    fs_n = 1'b0; step(4);
    put_bits(16'hFFFF, 15, 0);
    fs_n = 1'b1; step(6);
    chk(n_commit == c, "R8 unarmed start ignored", 32'(n_commit), 32'(c));
    chk(word == 16'h3C96, "R8 word unchanged", 32'(word), 32'h3C96);

    // R9: FS re-fall inside a DSP frame ignored
    c = n_commit;
    fs_n = 1'b0; step(4);
    put_bits(16'hC3A1, 15, 12);
    fs_n = 1'b1; step(4);
    fs_n = 1'b0; step(4);
    put_bits(16'hC3A1, 11, 0);
    step(4);
    chk(word == 16'hC3A1, "R9 restart ignored", 32'(word), 32'hC3A1);
    chk(n_commit == c + 1, "R9 single commit", 32'(n_commit), 32'(c + 1));
    fs_n = 1'b1; step(6);

    // R10: disabled output stays low while the line keeps shifting
    dsp = 1'b0; den = 1'b0; step(2);
    fs_n = 1'b0; step(4);
    put_bits(16'h9E35, 15, 0);
    chk(dout == 1'b0, "R10 disabled dout low", 32'(dout), 0);
    fs_n = 1'b1; step(6);
    den = 1'b1; #1;
    chk(dout == 1'b1, "R10 enabled reveals bit 15", 32'(dout), 1);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    step(1);
    chk(dout == 1'b1, "R10 delayed bit 12", 32'(dout), 1);
    chk(word == 16'h9E35, "R4 last committed word", 32'(word), 32'h9E35);
    step(8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule